// File: doc/BRIEF.md
# Per-Core Idle Power-State Sequencer

This block moves each core of a multicore chip between full operation and three idle levels of increasing depth. The lightest level stops only the execution-unit clocks. The middle level first asks for a cache purge and, once that is acknowledged, stops the whole core clock. The deepest level is a chip-wide mode. It is entered only when every core already sits in the middle level. It saves core state into retention storage and asks for the supply to be lowered. On the way out it requests a voltage ramp, waits for the supply to report good, and restores the saved state before any clock runs again.

Every exit path is timed by a countdown clocked by a one-microsecond tick pulse. The budgets are parameters, defaulting to 5, 1000 and 2000 ticks for the three levels. A core reports ready only after its budget has been used up. The cache flush machinery, the regulator and the retention cells are outside this block; it only drives their request and strobe lines.

Per-core states: RUN, NAP (execution clocks gated), PURGE (waiting for purge acknowledge), SLEEP (core clock gated), DEEP (held by chip controller), XNAP and XSLP (exit countdown). Per-core transitions: RUN→PURGE on a sleep request (wins over nap), RUN→NAP on a nap request, NAP→XNAP on wake, PURGE→SLEEP on purge acknowledge, SLEEP→DEEP when the chip controller saves state, SLEEP→XSLP on wake or a wake remembered from PURGE, DEEP→RUN when the chip controller restores, and XNAP/XSLP→RUN at count zero. Chip states: IDLE, SAVE, LOW, RAMP, RESTORE. Chip transitions: IDLE→SAVE on a deep request with every core eligible, SAVE→LOW always, LOW→RAMP on any wake or a wake remembered from SAVE, RAMP→RESTORE at count zero with supply good, and RESTORE→IDLE always.

Top module: `idle_seq_top`

## Requirements
- R1: After reset every core has both clock enables high and ready high; purge, save, restore, voltage-lower and voltage-ramp outputs are low.
- R2: A nap request to a running core drops its execution clock enable and its ready on the next edge, while its core clock enable stays high.
- R3: A sleep request (which wins over a simultaneous nap request) raises purge request and drops the execution clock enable on the next edge. The core clock stays enabled until purge acknowledge is sampled. On that edge purge request falls and the core clock enable falls.
- R4: Waking a napping core loads a 5-tick budget on the wake edge. With a tick on every edge, ready and the execution clock enable return 6 edges after the wake edge and not earlier.
- R5: Waking a sleeping core re-enables its core clock on the wake edge and loads a 1000-tick budget. Ready and the execution clock enable return 1001 edges after the wake edge.
- R6: A wake request seen while a purge is pending is remembered. The core still completes purge and spends one cycle with its core clock gated, then starts its sleep exit countdown.
- R7: Exit countdowns advance only on edges where the microsecond tick is high; without ticks a waking core never becomes ready.
- R8: A deep request is acted on only while every core is in SLEEP with no wake pending. It then produces a one-cycle save strobe on all cores followed by a held voltage-lower request; a deep request at any other time changes nothing.
- R9: Any wake request while the chip is lowered (or one seen during the save cycle) drops voltage-lower, raises voltage-ramp and loads a 2000-tick budget. When the budget is spent and supply-good is high, a one-cycle restore strobe is issued with all clocks still gated. All cores return to run with ready on the following edge.
- R10: While supply-good is low the deep exit stalls after its budget: no restore strobe and no ready.
- R11: A wake request to a core that is already running has no effect on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| nap_req | input | NCORES | Per-core request to enter nap |
| sleep_req | input | NCORES | Per-core request to enter sleep |
| wake_req | input | NCORES | Per-core request to return to run |
| purge_done | input | NCORES | Per-core cache purge acknowledge |
| deep_req | input | 1 | Chip-level request for the deepest idle level |
| vdd_good | input | 1 | Supply reports full voltage |
| eu_clk_en | output | NCORES | Execution-unit clock enable |
| core_clk_en | output | NCORES | Whole-core clock enable |
| purge_req | output | NCORES | Cache purge request |
| ret_save | output | NCORES | Retention save strobe |
| ret_restore | output | NCORES | Retention restore strobe |
| core_ready | output | NCORES | Core may resume execution |
| v_lower | output | 1 | Request to lower core and cache supply |
| v_ramp | output | 1 | Request to ramp supply back to full |

## Verification
A core stuck in the wrong state shows up on its enables within one edge of the request: a nap that gates the whole core, or a sleep that drops the core clock before purge acknowledge, is visible immediately on the clock enables and purge request. A corrupted countdown shows up only at the end of an exit, as ready arriving early, late or never. The bench therefore pins the exact edge on which ready returns for every budget. A chip controller entering or leaving the deep level at the wrong moment shows as a save strobe while a core is still awake, or as a restore strobe without supply-good, on the same edge that the fault occurs.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [2:0] {
        C_RUN,
        C_NAP,
        C_PURGE,
        C_SLEEP,
        C_DEEP,
        C_XNAP,
        C_XSLP
    } core_st_t;

    typedef enum logic [2:0] {
        H_IDLE,
        H_SAVE,
        H_LOW,
        H_RAMP,
        H_RESTORE
    } chip_st_t;

endpackage

// File: rtl/idle_core_fsm.sv
module idle_core_fsm
    import idle_pkg::*;
#(
    parameter int NAP_US = 5,
    parameter int SLP_US = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic nap_req,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic purge_done,
    input  logic deep_go,
    input  logic deep_release,
    output logic can_deep,
    output logic eu_clk_en,
    output logic core_clk_en,
    output logic purge_req,
    output logic core_ready
);

    localparam int MAXB = (NAP_US > SLP_US) ? NAP_US : SLP_US;
    localparam int CW   = $clog2(MAXB + 1);

    core_st_t        state, nxt;
    logic [CW-1:0]   cnt;
    logic            wake_pend;
    logic            load_nap, load_slp, counting;

    assign load_nap = (state == C_NAP) && wake_req;
    assign load_slp = (state == C_SLEEP) && !deep_go && (wake_req || wake_pend);
    assign counting = (state == C_XNAP) || (state == C_XSLP);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            C_RUN:   if (sleep_req) nxt = C_PURGE;
                     else if (nap_req) nxt = C_NAP;
            C_NAP:   if (wake_req) nxt = C_XNAP;
            C_PURGE: if (purge_done) nxt = C_SLEEP;
            C_SLEEP: if (deep_go) nxt = C_DEEP;
                     else if (wake_req || wake_pend) nxt = C_XSLP;
            C_DEEP:  if (deep_release) nxt = C_RUN;
            C_XNAP,
            C_XSLP:  if (cnt == '0) nxt = C_RUN;
            default: nxt = C_RUN;
        endcase
    end

    // state register, countdown and remembered wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= C_RUN;
            cnt       <= '0;
            wake_pend <= 1'b0;
        end else begin
            state     <= nxt;
            wake_pend <= (state == C_PURGE) && (wake_pend || wake_req);
            if (load_nap)
                cnt <= CW'(NAP_US);
            else if (load_slp)
                cnt <= CW'(SLP_US);
            else if (counting && us_tick && (cnt != '0))
                cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        eu_clk_en   = 1'b0;
        core_clk_en = 1'b0;
        purge_req   = 1'b0;
        core_ready  = 1'b0;
        unique case (state)
            C_RUN: begin
                eu_clk_en   = 1'b1;
                core_clk_en = 1'b1;
                core_ready  = 1'b1;
            end
            C_NAP, C_XNAP, C_XSLP: core_clk_en = 1'b1;
            C_PURGE: begin
                core_clk_en = 1'b1;
                purge_req   = 1'b1;
            end
            C_SLEEP, C_DEEP: ;
            default: ;
        endcase
    end

    assign can_deep = (state == C_SLEEP) && !wake_pend && !wake_req;

    // R3
    purge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_req && !purge_done) |=> purge_req);

    // R3
    eu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> !$past(eu_clk_en));

    // R7
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !us_tick && !load_nap && !load_slp && (cnt != '0)) |=> $stable(cnt));

    // R4 R5
    ready_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_ready) && !$past(state == C_DEEP)) |-> ($past(cnt) == '0));

endmodule

// File: rtl/idle_deep_ctrl.sv
module idle_deep_ctrl
    import idle_pkg::*;
#(
    parameter int DEEP_US = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic deep_req,
    input  logic all_can_deep,
    input  logic any_wake,
    input  logic vdd_good,
    output logic save_stb,
    output logic restore_stb,
    output logic v_lower,
    output logic v_ramp
);

    localparam int DW = $clog2(DEEP_US + 1);

    chip_st_t       state, nxt;
    logic [DW-1:0]  cnt;
    logic           wake_pend;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            H_IDLE:    if (deep_req && all_can_deep) nxt = H_SAVE;
            H_SAVE:    nxt = H_LOW;
            H_LOW:     if (any_wake || wake_pend) nxt = H_RAMP;
            H_RAMP:    if ((cnt == '0) && vdd_good) nxt = H_RESTORE;
            H_RESTORE: nxt = H_IDLE;
            default:   nxt = H_IDLE;
        endcase
    end

    // state register and ramp countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= H_IDLE;
            cnt       <= '0;
            wake_pend <= 1'b0;
        end else begin
            state     <= nxt;
            wake_pend <= (state == H_SAVE) && any_wake;
            if ((state == H_LOW) && (nxt == H_RAMP))
                cnt <= DW'(DEEP_US);
            else if ((state == H_RAMP) && us_tick && (cnt != '0))
                cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        save_stb    = 1'b0;
        restore_stb = 1'b0;
        v_lower     = 1'b0;
        v_ramp      = 1'b0;
        unique case (state)
            H_IDLE:    ;
            H_SAVE:    save_stb    = 1'b1;
            H_LOW:     v_lower     = 1'b1;
            H_RAMP:    v_ramp      = 1'b1;
            H_RESTORE: restore_stb = 1'b1;
            default:   ;
        endcase
    end

    // R8
    save_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_stb) |-> $past(deep_req && all_can_deep));

    // R8
    save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_stb |=> !save_stb);

    // R9
    supply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({v_lower, v_ramp, save_stb, restore_stb}));

    // R10
    restore_vgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_stb |-> ($past(vdd_good) && $past(v_ramp)));

endmodule

// File: rtl/idle_seq_top.sv
module idle_seq_top
    import idle_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int NAP_US  = 5,
    parameter int SLP_US  = 1000,
    parameter int DEEP_US = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [NCORES-1:0] nap_req,
    input  logic [NCORES-1:0] sleep_req,
    input  logic [NCORES-1:0] wake_req,
    input  logic [NCORES-1:0] purge_done,
    input  logic              deep_req,
    input  logic              vdd_good,
    output logic [NCORES-1:0] eu_clk_en,
    output logic [NCORES-1:0] core_clk_en,
    output logic [NCORES-1:0] purge_req,
    output logic [NCORES-1:0] ret_save,
    output logic [NCORES-1:0] ret_restore,
    output logic [NCORES-1:0] core_ready,
    output logic              v_lower,
    output logic              v_ramp
);

    logic [NCORES-1:0] can_deep;
    logic              save_stb, restore_stb;

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        idle_core_fsm #(
            .NAP_US (NAP_US),
            .SLP_US (SLP_US)
        ) i_core (
            .clk          (clk),
            .rst_n        (rst_n),
            .us_tick      (us_tick),
            .nap_req      (nap_req[g]),
            .sleep_req    (sleep_req[g]),
            .wake_req     (wake_req[g]),
            .purge_done   (purge_done[g]),
            .deep_go      (save_stb),
            .deep_release (restore_stb),
            .can_deep     (can_deep[g]),
            .eu_clk_en    (eu_clk_en[g]),
            .core_clk_en  (core_clk_en[g]),
            .purge_req    (purge_req[g]),
            .core_ready   (core_ready[g])
        );
    end

    idle_deep_ctrl #(
        .DEEP_US (DEEP_US)
    ) i_deep (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick      (us_tick),
        .deep_req     (deep_req),
        .all_can_deep (&can_deep),
        .any_wake     (|wake_req),
        .vdd_good     (vdd_good),
        .save_stb     (save_stb),
        .restore_stb  (restore_stb),
        .v_lower      (v_lower),
        .v_ramp       (v_ramp)
    );

    assign ret_save    = {NCORES{save_stb}};
    assign ret_restore = {NCORES{restore_stb}};

    // R9
    restore_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_restore[0] |-> ((core_clk_en == '0) && (core_ready == '0)));

    // R8
    save_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_save[0] |-> (core_clk_en == '0));

endmodule

// File: tb/test_idle_seq_top.sv
module test_idle_seq_top;

    localparam int N    = 4;
    localparam int NAPB = 5;
    localparam int SLPB = 1000;
    localparam int DPB  = 2000;

    logic         clk = 1'b0;
    logic         rst_n, us_tick, deep_req, vdd_good;
    logic [N-1:0] nap_req, sleep_req, wake_req, purge_done;
    logic [N-1:0] eu_clk_en, core_clk_en, purge_req, ret_save, ret_restore, core_ready;
    logic         v_lower, v_ramp;

    int n_chk  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    idle_seq_top #(.NCORES(N), .NAP_US(NAPB), .SLP_US(SLPB), .DEEP_US(DPB)) i_idle_seq_top (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .nap_req(nap_req), .sleep_req(sleep_req), .wake_req(wake_req),
        .purge_done(purge_done), .deep_req(deep_req), .vdd_good(vdd_good),
        .eu_clk_en(eu_clk_en), .core_clk_en(core_clk_en), .purge_req(purge_req),
        .ret_save(ret_save), .ret_restore(ret_restore), .core_ready(core_ready),
        .v_lower(v_lower), .v_ramp(v_ramp)
    );

    function automatic logic [N-1:0] bit_of(int c);
        return N'(1) << c;
    endfunction

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected per-core run-state triple {eu, core, ready} packed as 3 bits
    function automatic logic [2:0] exp_run(bit eu, bit cc, bit rdy);
        return {eu, cc, rdy};
    endfunction

    function automatic logic [2:0] core_obs(int c);
        return {eu_clk_en[c], core_clk_en[c], core_ready[c]};
    endfunction

    task automatic do_nap(int c, int hold);
        nap_req = bit_of(c);
        step();
        nap_req = '0;
        chk("R2 nap entry", core_obs(c), exp_run(0, 1, 0));
        step(hold);
        wake_req = bit_of(c);
        step();
        wake_req = '0;
        step(NAPB);
        chk("R4 nap not early", core_obs(c), exp_run(0, 1, 0));
        step();
        chk("R4 nap ready", core_obs(c), exp_run(1, 1, 1));
    endtask

    task automatic do_sleep(int c, int pd, bit wake_early, bit with_nap);
        sleep_req = bit_of(c);
        nap_req   = with_nap ? bit_of(c) : '0;
        step();
        sleep_req = '0;
        nap_req   = '0;
        chk("R3 purge raised", {31'd0, purge_req[c]}, 32'd1);
        chk("R3 purge entry clocks", core_obs(c), exp_run(0, 1, 0));
        if (wake_early) begin
            wake_req = bit_of(c);
            step();
            wake_req = '0;
        end
        step(pd);
        chk("R3 purge held", {31'd0, purge_req[c]}, 32'd1);
        purge_done = bit_of(c);
        step();
        purge_done = '0;
        chk("R3 sleep gated", {29'd0, purge_req[c], core_clk_en[c], eu_clk_en[c]}, 32'd0);
        if (wake_early) begin
            chk("R6 gated one cycle", {31'd0, core_clk_en[c]}, 32'd0);
        end else begin
            step(3);
            wake_req = bit_of(c);
        end
        step();
        wake_req = '0;
        chk(wake_early ? "R6 exit started" : "R5 exit clocks", core_obs(c), exp_run(0, 1, 0));
        step(SLPB);
        chk("R5 sleep not early", core_obs(c), exp_run(0, 1, 0));
        step();
        chk("R5 sleep ready", core_obs(c), exp_run(1, 1, 1));
    endtask

    task automatic all_to_sleep();
        sleep_req = '1;
        step();
        sleep_req  = '0;
        purge_done = '1;
        step();
        purge_done = '0;
        chk("R3 all gated", {28'd0, core_clk_en}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; us_tick = 1'b1; deep_req = 1'b0; vdd_good = 1'b1;
        nap_req = '0; sleep_req = '0; wake_req = '0; purge_done = '0;
        void'($urandom(32'd4711));
        step(3);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 eu", {28'd0, eu_clk_en}, 32'hF);
        chk("R1 core", {28'd0, core_clk_en}, 32'hF);
        chk("R1 ready", {28'd0, core_ready}, 32'hF);
        chk("R1 strobes", {16'd0, purge_req, ret_save, ret_restore, 2'b00, v_lower, v_ramp}, 32'd0);

        // R11 wake while running
        wake_req = '1;
        step();
        wake_req = '0;
        step();
        chk("R11 wake in run", {20'd0, eu_clk_en, core_clk_en, core_ready}, 32'hFFF);

        // directed nap and sleep
        do_nap(1, 3);
        do_sleep(2, 4, 1'b0, 1'b1);
        do_sleep(0, 2, 1'b1, 1'b0);

        // R7 no tick, no progress
        nap_req = bit_of(3);
        step();
        nap_req = '0;
        us_tick = 1'b0;
        wake_req = bit_of(3);
        step();
        wake_req = '0;
        step(50);
        chk("R7 stalled without tick", core_obs(3), exp_run(0, 1, 0));
        us_tick = 1'b1;
        step(NAPB);
        chk("R7 resumed not early", {31'd0, core_ready[3]}, 32'd0);
        step();
        chk("R7 resumed ready", {31'd0, core_ready[3]}, 32'd1);

        // random nap / sleep scenarios
        for (int k = 0; k < 6; k++) begin
            int c  = int'($urandom % N);
            int op = int'($urandom % 2);
            int w  = int'($urandom % 8) + 1;
            int pd = int'($urandom % 6) + 1;
            bit we = bit'($urandom % 2);
            if (op == 0) do_nap(c, w);
            else do_sleep(c, pd, we, 1'b0);
        end

        // R8 deep request while not all asleep is ignored
        sleep_req = 4'b0011;
        step();
        sleep_req = '0;
        deep_req = 1'b1;
        step();
        deep_req = 1'b0;
        chk("R8 ignored save", {28'd0, ret_save}, 32'd0);
        step();
        chk("R8 ignored lower", {31'd0, v_lower}, 32'd0);
        purge_done = 4'b0011;
        step();
        purge_done = '0;
        wake_req = 4'b0011;
        step();
        wake_req = '0;
        step(SLPB + 2);
        chk("R5 pair back", {28'd0, core_ready}, 32'hF);

        // R8 R9 R10 full deep cycle with late supply-good
        all_to_sleep();
        deep_req = 1'b1;
        step();
        deep_req = 1'b0;
        chk("R8 save pulse", {28'd0, ret_save}, 32'hF);
        chk("R8 not yet lowered", {31'd0, v_lower}, 32'd0);
        step();
        chk("R8 save ends", {28'd0, ret_save}, 32'd0);
        chk("R8 lowered", {31'd0, v_lower}, 32'd1);
        vdd_good = 1'b0;
        step(5);
        chk("R8 lower held", {31'd0, v_lower}, 32'd1);
        wake_req = bit_of(2);
        step();
        wake_req = '0;
        chk("R9 ramp on", {30'd0, v_lower, v_ramp}, 32'd1);
        step(DPB + 1);
        chk("R10 no restore", {28'd0, ret_restore}, 32'd0);
        step(10);
        chk("R10 no ready", {28'd0, core_ready}, 32'd0);
        vdd_good = 1'b1;
        step();
        chk("R9 restore strobe", {28'd0, ret_restore}, 32'hF);
        chk("R9 clocks still off", {28'd0, core_clk_en}, 32'd0);
        step();
        chk("R9 all ready", {20'd0, eu_clk_en, core_clk_en, core_ready}, 32'hFFF);
        chk("R9 supply idle", {30'd0, v_lower, v_ramp}, 32'd0);

        // R9 wake seen during the save cycle, exact timing
        all_to_sleep();
        deep_req = 1'b1;
        step();
        deep_req = 1'b0;
        wake_req = bit_of(1);
        step();
        wake_req = '0;
        chk("R9 lowered after pending wake", {30'd0, v_lower, v_ramp}, 32'd2);
        step();
        chk("R9 pending wake ramps", {30'd0, v_lower, v_ramp}, 32'd1);
        step(DPB);
        chk("R9 budget not early", {28'd0, ret_restore}, 32'd0);
        step();
        chk("R9 restore on time", {28'd0, ret_restore}, 32'hF);
        step();
        chk("R9 ready on time", {28'd0, core_ready}, 32'hF);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=finished", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule